// File: doc/BRIEF.md
# SDRAM Command and Mode Decoder

This block sits behind the control pins of a synchronous DRAM device model or controller-side monitor. On every rising clock edge it samples the clock-enable pair (the level seen on the previous edge and the level on this edge), the select and the three strobe pins, the bank bits and the address. It turns that combination into a single registered command strobe. Loads of the two configuration registers are recognised from the same pins. The standard register is chosen when both bank bits are zero, and the extended register when the upper bank bit is one and the lower is zero.

The standard register carries read latency, burst ordering and burst length. The extended register carries the refresh temperature range and the portion of the array kept alive during self refresh. Both are exported in decoded form: a latency count, a beat count, a per-bank refresh mask and the number of row MSBs that must be zero. A load whose code is reserved leaves the register untouched and raises a single-cycle error pulse.

Top module: `sdcmd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, all strobes, auto_pre, pre_all and load_error clear. The standard register returns to latency 3, sequential ordering and 1 beat. The extended register returns to full coverage and temperature code 00.
- R2: With clock enable high on both edges, the strobe bit is set one clock after the sample. The bits are: bit0 deselect (cs_n high), bit1 no-op (ras/cas/we = 1/1/1), bit2 activate (0/1/1), bit3 read (1/0/1), bit4 write (1/0/0), bit5 precharge (0/1/0), bit6 burst stop (1/1/0), bit7 auto refresh (0/0/1).
- R3: When cke_prev is low, no strobe is raised, no error is raised and neither register changes.
- R4: When cke_prev is high and cke_now is low, the pins select a strobe. Select low with 0/0/1 sets bit8 (self refresh entry). Select low with 1/1/0 sets bit9 (deep power down entry). Select low with 0/0/0 is still a register load. Anything else sets bit12 (power-down or clock-suspend entry).
- R5: A load (select low, 0/0/0) with bank = 00 sets bit10 and targets the standard register. With bank = 10 it sets bit11 and targets the extended register. With bank 01 or 11 it sets no strobe, raises load_error and changes neither register.
- R6: Latency code addr[6:4] = 001, 010 or 011 gives cas_latency 1, 2 or 3. Every other code is reserved.
- R7: addr[3] = 1 selects interleaved ordering. Length code addr[2:0] of 000 to 011 gives 1, 2, 4 or 8 beats on burst_beats. Code 111 with sequential ordering gives a full page of 2^COL_BITS beats. Code 111 with interleave is reserved, as are 100, 101 and 110.
- R8: In the extended register, addr[4:3] is exported as temp_range. Coverage addr[2:0] drives the outputs as follows: 000 gives mask 1111 and 0 row MSBs. 001 gives mask 0011 and 0. 010 gives mask 0001 and 0. 101 gives mask 0001 and 1. 110 gives mask 0001 and 2. Codes 011, 100 and 111 are reserved.
- R9: A load carrying a reserved code keeps the previous contents of the target register and raises load_error for exactly the following clock.
- R10: auto_pre is addr[10] registered alongside a read or write strobe. pre_all is addr[10] registered alongside a precharge strobe. Both are low with every other command.
- R11: At most one strobe bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_prev | input | 1 | Clock-enable level on the previous edge |
| cke_now | input | 1 | Clock-enable level on this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| bank | input | 2 | Bank bits |
| addr | input | 12 | Address / opcode bits |
| cmd_strobe | output | 13 | One-hot registered command strobe |
| auto_pre | output | 1 | Read/write with auto precharge |
| pre_all | output | 1 | Precharge of all banks |
| cas_latency | output | 2 | Read latency in clocks |
| burst_interleave | output | 1 | Interleaved burst ordering |
| burst_beats | output | 10 | Burst length in beats |
| temp_range | output | 2 | Temperature range code |
| refresh_bank_mask | output | 4 | Banks kept during self refresh |
| refresh_row_msb_zero | output | 2 | Row MSBs forced to zero during self refresh |
| load_error | output | 1 | Reserved-code or bad-select load pulse |

## Verification
The hardest conditions to reach are those where the clock-enable edge changes the meaning of otherwise ordinary pin codes. Examples are a burst-stop code turning into deep power down, or a load arriving while cke_prev is low, which must leave both registers exactly as they were. Back-to-back reserved loads are also hard to reach, because they must keep load_error high without disturbing the stored fields. The stimulus drives directed sequences for each clock-enable transition, followed by a long run of random pin patterns in which clock enable is low a quarter of the time. The bench follows the stored fields in a behavioural model, so a missed hold is seen at the exported outputs.

// File: rtl/sdcmd_pkg.sv
// Shared command indices, pin patterns and register field types for the
// SDRAM command decoder. Pin patterns are {ras_n, cas_n, we_n}.
package sdcmd_pkg;

    localparam int CMD_DESEL = 0;
    localparam int CMD_NOP   = 1;
    localparam int CMD_ACT   = 2;
    localparam int CMD_RD    = 3;
    localparam int CMD_WR    = 4;
    localparam int CMD_PRE   = 5;
    localparam int CMD_BST   = 6;
    localparam int CMD_AREF  = 7;
    localparam int CMD_SREF  = 8;
    localparam int CMD_DPD   = 9;
    localparam int CMD_LMR   = 10;
    localparam int CMD_LEMR  = 11;
    localparam int CMD_PDN   = 12;
    localparam int CMD_COUNT = 13;

    localparam logic [2:0] PAT_LOAD = 3'b000;
    localparam logic [2:0] PAT_AREF = 3'b001;
    localparam logic [2:0] PAT_PRE  = 3'b010;
    localparam logic [2:0] PAT_ACT  = 3'b011;
    localparam logic [2:0] PAT_WR   = 3'b100;
    localparam logic [2:0] PAT_RD   = 3'b101;
    localparam logic [2:0] PAT_BST  = 3'b110;
    localparam logic [2:0] PAT_NOP  = 3'b111;

    localparam logic [2:0] COV_ALL     = 3'b000;
    localparam logic [2:0] COV_HALF    = 3'b001;
    localparam logic [2:0] COV_QUARTER = 3'b010;
    localparam logic [2:0] COV_EIGHTH  = 3'b101;
    localparam logic [2:0] COV_SIXTEEN = 3'b110;

    typedef struct packed {
        logic [1:0] lat;
        logic       ilv;
        logic [2:0] len;
    } mode_fields_t;

    typedef struct packed {
        logic [1:0] temp;
        logic [2:0] cov;
    } ext_fields_t;

endpackage

// File: rtl/sdcmd_pin_decode.sv
// Combinational pin decoder: maps clock-enable pair, select and strobe pins
// to at most one command bit, plus register-load target selects.
// Assumes the caller registers the result; no state is held here.
module sdcmd_pin_decode
    import sdcmd_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                 cke_prev,
    input  logic                 cke_now,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    bank,
    output logic [CMD_COUNT-1:0] cmd_vec,
    output logic                 mr_sel,
    output logic                 emr_sel,
    output logic                 bad_sel
);

    localparam logic [BANK_W-1:0] SEL_MR  = BANK_W'(0);
    localparam logic [BANK_W-1:0] SEL_EMR = BANK_W'(2);

    logic [2:0] rcw;
    logic       is_load;

    // Pin pattern and load recognition shared by both clock-enable cases.
    always_comb begin
        rcw     = {ras_n, cas_n, we_n};
        is_load = !cs_n && (rcw == PAT_LOAD);
    end

    // Command selection by clock-enable transition and pin pattern.
    always_comb begin
        cmd_vec = '0;
        mr_sel  = 1'b0;
        emr_sel = 1'b0;
        bad_sel = 1'b0;
        if (cke_prev) begin
            if (is_load) begin
                if (bank == SEL_MR) begin
                    cmd_vec[CMD_LMR] = 1'b1;
                    mr_sel           = 1'b1;
                end else if (bank == SEL_EMR) begin
                    cmd_vec[CMD_LEMR] = 1'b1;
                    emr_sel           = 1'b1;
                end else begin
                    bad_sel = 1'b1;
                end
            end else if (cke_now) begin
                if (cs_n) begin
                    cmd_vec[CMD_DESEL] = 1'b1;
                end else begin
                    case (rcw)
                        PAT_ACT:  cmd_vec[CMD_ACT]  = 1'b1;
                        PAT_RD:   cmd_vec[CMD_RD]   = 1'b1;
                        PAT_WR:   cmd_vec[CMD_WR]   = 1'b1;
                        PAT_PRE:  cmd_vec[CMD_PRE]  = 1'b1;
                        PAT_BST:  cmd_vec[CMD_BST]  = 1'b1;
                        PAT_AREF: cmd_vec[CMD_AREF] = 1'b1;
                        default:  cmd_vec[CMD_NOP]  = 1'b1;
                    endcase
                end
            end else begin
                if (!cs_n && rcw == PAT_AREF) begin
                    cmd_vec[CMD_SREF] = 1'b1;
                end else if (!cs_n && rcw == PAT_BST) begin
                    cmd_vec[CMD_DPD] = 1'b1;
                end else begin
                    cmd_vec[CMD_PDN] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdcmd_mode_reg.sv
// Standard mode register: validates latency and burst codes on a load,
// stores them only when legal, and exports latency and beat count.
// Assumes field = addr[6:0]; upper address bits are ignored.
module sdcmd_mode_reg
    import sdcmd_pkg::*;
#(
    parameter int COL_BITS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [6:0]        field,
    output logic [1:0]        cas_latency,
    output logic              burst_interleave,
    output logic [COL_BITS:0] burst_beats,
    output logic              reject
);

    localparam int BEATS_W = COL_BITS + 1;

    mode_fields_t cur_q;
    logic         lat_ok;
    logic         len_ok;

    // Legality of the incoming codes.
    always_comb begin
        lat_ok = (field[6:4] == 3'd1) || (field[6:4] == 3'd2) || (field[6:4] == 3'd3);
        len_ok = (field[2:0] <= 3'd3) || ((field[2:0] == 3'd7) && !field[3]);
        reject = !(lat_ok && len_ok);
    end

    // Register update: legal loads only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.lat <= 2'd3;
            cur_q.ilv <= 1'b0;
            cur_q.len <= 3'd0;
        end else if (load && !reject) begin
            cur_q.lat <= field[5:4];
            cur_q.ilv <= field[3];
            cur_q.len <= field[2:0];
        end
    end

    // Export: beat count from the stored length code.
    always_comb begin
        cas_latency      = cur_q.lat;
        burst_interleave = cur_q.ilv;
        if (cur_q.len == 3'd7) begin
            burst_beats = BEATS_W'(1) << COL_BITS;
        end else begin
            burst_beats = BEATS_W'(1) << cur_q.len[1:0];
        end
    end

endmodule

// File: rtl/sdcmd_ext_reg.sv
// Extended mode register: validates refresh coverage, stores temperature
// and coverage codes, and expands coverage into a per-bank mask and a
// count of row MSBs held at zero. Assumes BANKS is a multiple of four.
module sdcmd_ext_reg
    import sdcmd_pkg::*;
#(
    parameter int BANKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [4:0]       field,
    output logic [1:0]       temp_range,
    output logic [BANKS-1:0] bank_mask,
    output logic [1:0]       row_msb_zero,
    output logic             reject
);

    ext_fields_t cur_q;

    // Legality of the incoming coverage code.
    always_comb begin
        reject = !((field[2:0] == COV_ALL) || (field[2:0] == COV_HALF) ||
                   (field[2:0] == COV_QUARTER) || (field[2:0] == COV_EIGHTH) ||
                   (field[2:0] == COV_SIXTEEN));
    end

    // Register update: legal loads only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.temp <= 2'b00;
            cur_q.cov  <= COV_ALL;
        end else if (load && !reject) begin
            cur_q.temp <= field[4:3];
            cur_q.cov  <= field[2:0];
        end
    end

    // Per-bank mask: each bank decides from its own index.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam bit IN_HALF    = (b < BANKS / 2);
        localparam bit IN_QUARTER = (b < BANKS / 4);
        always_comb begin
            case (cur_q.cov)
                COV_HALF:                         bank_mask[b] = IN_HALF;
                COV_QUARTER, COV_EIGHTH, COV_SIXTEEN: bank_mask[b] = IN_QUARTER;
                default:                          bank_mask[b] = 1'b1;
            endcase
        end
    end

    // Row trimming and temperature export.
    always_comb begin
        temp_range = cur_q.temp;
        case (cur_q.cov)
            COV_EIGHTH:  row_msb_zero = 2'd1;
            COV_SIXTEEN: row_msb_zero = 2'd2;
            default:     row_msb_zero = 2'd0;
        endcase
    end

endmodule

// File: rtl/sdcmd_decoder.sv
// Top of the SDRAM command and mode decoder. Registers the one-hot command
// strobe, the address-bit-10 qualifiers and the load error pulse, and
// holds both configuration registers. Assumes ADDR_W > 10 and BANKS = 2^BANK_W.
module sdcmd_decoder
    import sdcmd_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int ADDR_W   = 12,
    parameter int COL_BITS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_prev,
    input  logic                 cke_now,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [1:0]           bank,
    input  logic [ADDR_W-1:0]    addr,
    output logic [CMD_COUNT-1:0] cmd_strobe,
    output logic                 auto_pre,
    output logic                 pre_all,
    output logic [1:0]           cas_latency,
    output logic                 burst_interleave,
    output logic [COL_BITS:0]    burst_beats,
    output logic [1:0]           temp_range,
    output logic [BANKS-1:0]     refresh_bank_mask,
    output logic [1:0]           refresh_row_msb_zero,
    output logic                 load_error
);

    localparam int AP_BIT = 10;

    logic [CMD_COUNT-1:0] cmd_vec;
    logic mr_sel, emr_sel, bad_sel;
    logic mr_rej, emr_rej;

    sdcmd_pin_decode #(.BANK_W(2)) u_pins (
        .cke_prev (cke_prev),
        .cke_now  (cke_now),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank     (bank),
        .cmd_vec  (cmd_vec),
        .mr_sel   (mr_sel),
        .emr_sel  (emr_sel),
        .bad_sel  (bad_sel)
    );

    sdcmd_mode_reg #(.COL_BITS(COL_BITS)) u_mode (
        .clk              (clk),
        .rst_n            (rst_n),
        .load             (mr_sel),
        .field            (addr[6:0]),
        .cas_latency      (cas_latency),
        .burst_interleave (burst_interleave),
        .burst_beats      (burst_beats),
        .reject           (mr_rej)
    );

    sdcmd_ext_reg #(.BANKS(BANKS)) u_ext (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (emr_sel),
        .field        (addr[4:0]),
        .temp_range   (temp_range),
        .bank_mask    (refresh_bank_mask),
        .row_msb_zero (refresh_row_msb_zero),
        .reject       (emr_rej)
    );

    // Output stage: strobe, qualifiers and error pulse, one clock after sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= '0;
            auto_pre   <= 1'b0;
            pre_all    <= 1'b0;
            load_error <= 1'b0;
        end else begin
            cmd_strobe <= cmd_vec;
            auto_pre   <= (cmd_vec[CMD_RD] | cmd_vec[CMD_WR]) & addr[AP_BIT];
            pre_all    <= cmd_vec[CMD_PRE] & addr[AP_BIT];
            load_error <= (mr_sel & mr_rej) | (emr_sel & emr_rej) | bad_sel;
        end
    end

endmodule

// File: rtl/sdcmd_decoder_chk.sv
// Property checker for sdcmd_decoder, attached by bind. Observes ports only.
module sdcmd_decoder_chk
    import sdcmd_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int ADDR_W   = 12,
    parameter int COL_BITS = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke_prev,
    input logic                 cke_now,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [1:0]           bank,
    input logic [ADDR_W-1:0]    addr,
    input logic [CMD_COUNT-1:0] cmd_strobe,
    input logic                 auto_pre,
    input logic                 pre_all,
    input logic [1:0]           cas_latency,
    input logic                 burst_interleave,
    input logic [COL_BITS:0]    burst_beats,
    input logic [1:0]           temp_range,
    input logic [BANKS-1:0]     refresh_bank_mask,
    input logic [1:0]           refresh_row_msb_zero,
    input logic                 load_error
);

    logic seen;

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe));

    a_r3_quiet_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(cke_prev)) |-> (cmd_strobe == '0 && !load_error));

    a_r9_error_holds_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && load_error) |-> ($stable(cas_latency) && $stable(burst_beats) &&
                                  $stable(burst_interleave) && $stable(temp_range) &&
                                  $stable(refresh_bank_mask)));

    a_r10_ap_with_column: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd_strobe[CMD_RD] || cmd_strobe[CMD_WR]));

    a_r10_all_with_pre: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> cmd_strobe[CMD_PRE]);

    a_r7_no_interleaved_page: assert property (@(posedge clk) disable iff (!rst_n)
        burst_interleave |-> !burst_beats[COL_BITS]);

    a_r6_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cas_latency != 2'd0);

    a_r8_trim_needs_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_row_msb_zero != 2'd0) |-> ($countones(refresh_bank_mask) == BANKS / 4));

endmodule

bind sdcmd_decoder sdcmd_decoder_chk #(
    .BANKS    (BANKS),
    .ADDR_W   (ADDR_W),
    .COL_BITS (COL_BITS)
) u_chk (.*);

// File: tb/sdcmd_decoder_tb.sv
// Bench for sdcmd_decoder: behavioural reference model stepped once per
// clock and compared against every output.
module sdcmd_decoder_tb;

    localparam int PERIOD = 10;
    localparam int NCMD   = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev, cke_now, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic [NCMD-1:0] cmd_strobe;
    logic auto_pre, pre_all, burst_interleave, load_error;
    logic [1:0] cas_latency, temp_range, refresh_row_msb_zero;
    logic [9:0] burst_beats;
    logic [3:0] refresh_bank_mask;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state.
    int m_lat, m_len, m_temp, m_cov;
    bit m_ilv;

    always #(PERIOD / 2) clk = ~clk;

    sdcmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_now(cke_now),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .cmd_strobe(cmd_strobe),
        .auto_pre(auto_pre), .pre_all(pre_all), .cas_latency(cas_latency),
        .burst_interleave(burst_interleave), .burst_beats(burst_beats),
        .temp_range(temp_range), .refresh_bank_mask(refresh_bank_mask),
        .refresh_row_msb_zero(refresh_row_msb_zero), .load_error(load_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    // Expected strobe index from the pins; -1 means no strobe.
    function automatic int expect_idx(bit pc, bit pn, bit cs, bit r, bit c, bit w, int b);
        bit lo = (!cs && !r && !c && !w);
        if (!pc) return -1;
        if (lo) return (b == 0) ? 10 : (b == 2) ? 11 : -1;
        if (!pn) begin
            if (!cs && !r && !c && w) return 8;
            if (!cs && r && c && !w) return 9;
            return 12;
        end
        if (cs) return 0;
        if (r && c && w)   return 1;
        if (!r && c && w)  return 2;
        if (r && !c && w)  return 3;
        if (r && !c && !w) return 4;
        if (!r && c && !w) return 5;
        if (r && c && !w)  return 6;
        return 7;
    endfunction

    task automatic apply(input bit pc, input bit pn, input bit cs, input bit r,
                         input bit c, input bit w, input int b, input int a);
        int idx, beats, mask, rows;
        bit e_ap, e_pa, e_err;
        string sreq;
        logic [NCMD-1:0] e_vec;
        cke_prev = pc; cke_now = pn; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        bank = 2'(b); addr = 12'(a);
        idx = expect_idx(pc, pn, cs, r, c, w, b);
        e_vec = (idx < 0) ? '0 : (NCMD'(1) << idx);
        e_ap = (idx == 3 || idx == 4) && a[10];
        e_pa = (idx == 5) && a[10];
        e_err = 0;
        if (pc && !cs && !r && !c && !w && b != 0 && b != 2) e_err = 1;  // R5
        if (idx == 10) begin
            int lc = (a >> 4) & 7; int ln = a & 7; bit il = a[3];
            if (lc >= 1 && lc <= 3 && (ln <= 3 || (ln == 7 && !il))) begin
                m_lat = lc; m_ilv = il; m_len = ln;
            end else e_err = 1;
        end
        if (idx == 11) begin
            int cv = a & 7;
            if (cv == 0 || cv == 1 || cv == 2 || cv == 5 || cv == 6) begin
                m_cov = cv; m_temp = (a >> 3) & 3;
            end else e_err = 1;
        end
        if (!rst_n) begin
            m_lat = 3; m_ilv = 0; m_len = 0; m_temp = 0; m_cov = 0;
            e_vec = '0; e_ap = 0; e_pa = 0; e_err = 0;
        end
        beats = (m_len == 7) ? 512 : (1 << m_len);
        mask  = (m_cov == 0) ? 15 : (m_cov == 1) ? 3 : 1;
        rows  = (m_cov == 5) ? 1 : (m_cov == 6) ? 2 : 0;
        @(negedge clk);
        sreq = !rst_n ? "R1" : !pc ? "R3" : !pn ? "R4" : "R2";
        check(cmd_strobe === e_vec, sreq, "cmd_strobe", int'(cmd_strobe), int'(e_vec));
        check($countones(cmd_strobe) <= 1, "R11", "strobe count", $countones(cmd_strobe), 1);
        check(auto_pre === e_ap && pre_all === e_pa, "R10", "ap/all",
              {auto_pre, pre_all}, {e_ap, e_pa});
        check(load_error === e_err, "R9", "load_error", int'(load_error), int'(e_err));
        check(cas_latency === 2'(m_lat), "R6", "cas_latency", int'(cas_latency), m_lat);
        check(burst_interleave === m_ilv && burst_beats === 10'(beats), "R7", "burst",
              int'(burst_beats), beats);
        check(temp_range === 2'(m_temp) && refresh_bank_mask === 4'(mask) &&
              refresh_row_msb_zero === 2'(rows), "R8", "ext fields",
              {temp_range, refresh_bank_mask, refresh_row_msb_zero}, (m_temp << 6) | (mask << 2) | rows);
    endtask

    // Register loads: standard (bank 00) and extended (bank 10).
    task automatic lmr(input int a);  apply(1, 1, 0, 0, 0, 0, 0, a); endtask
    task automatic lemr(input int a); apply(1, 1, 0, 0, 0, 0, 2, a); endtask

    initial begin
        @(negedge clk);
        rst_n = 0;
        apply(1, 1, 0, 1, 0, 1, 0, 12'h400);            // R1 reset state
        apply(1, 1, 0, 0, 0, 0, 0, 12'h023);
        rst_n = 1;
        // R2: each command with clock enable held high
        apply(1, 1, 1, 0, 0, 0, 0, 0);
        apply(1, 1, 0, 1, 1, 1, 0, 0);
        apply(1, 1, 0, 0, 1, 1, 1, 12'hABC);
        apply(1, 1, 0, 1, 0, 1, 3, 12'h400);            // R10 read with ap
        apply(1, 1, 0, 1, 0, 0, 2, 12'h000);            // write, no ap
        apply(1, 1, 0, 1, 0, 0, 2, 12'h400);
        apply(1, 1, 0, 0, 1, 0, 1, 12'h400);            // R10 pre all
        apply(1, 1, 0, 0, 1, 0, 1, 12'h000);
        apply(1, 1, 0, 1, 1, 0, 0, 12'h400);            // burst stop, a10 ignored
        apply(1, 1, 0, 0, 0, 1, 0, 0);
        // R6/R7: every latency and length code
        for (int lc = 0; lc < 8; lc++) lmr((lc << 4) | 2);
        for (int ln = 0; ln < 8; ln++) begin
            lmr(16'h20 | ln);
            lmr(16'h28 | ln);                            // interleave variants
        end
        lmr(12'h037); lmr(12'h03F); lmr(12'h03F);        // R9 back-to-back reserved
        // R8: temperature and coverage
        for (int cv = 0; cv < 8; cv++) for (int t = 0; t < 4; t++) lemr((t << 3) | cv);
        // R5: bad register select
        apply(1, 1, 0, 0, 0, 0, 1, 12'h012);
        apply(1, 1, 0, 0, 0, 0, 3, 12'h001);
        // R3: previous clock enable low, load ignored
        apply(0, 1, 0, 0, 0, 0, 0, 12'h011);
        apply(0, 0, 0, 0, 0, 0, 2, 12'h005);
        apply(0, 1, 0, 1, 0, 1, 0, 12'h400);
        // R4: clock-enable drop
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        apply(1, 0, 0, 1, 1, 0, 0, 0);
        apply(1, 0, 1, 1, 1, 1, 0, 0);
        apply(1, 0, 0, 1, 1, 1, 0, 0);
        apply(1, 0, 0, 0, 0, 0, 0, 12'h031);
        apply(1, 0, 0, 0, 0, 0, 2, 12'h006);
        // random pin patterns
        for (int i = 0; i < 3000; i++) begin
            int v = int'($urandom);
            apply((v & 3) != 0, ((v >> 2) & 3) != 0, (v >> 4) & 1, (v >> 5) & 1,
                  (v >> 6) & 1, (v >> 7) & 1, (v >> 8) & 3, (v >> 10) & 12'hFFF);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule